// File: doc/BRIEF.md
# Strobe-Qualified Parallel Word Capture

This block takes a parallel data word from a sender that runs without any timing relation to the local clock. The sender drives the data lines first. Once every line has settled, it raises a single strobe line. Only the strobe crosses into the local clock domain, through a chain of flip-flops. The data lines are never sampled for decisions. The block watches the synchronized strobe for a rising edge. On that edge it loads the whole bus into a capture register in one step, so skew between the data lines cannot produce a word made of two different values.

The loaded word is held on the output. A one-cycle valid pulse tells downstream logic that a new word is there. The sender must keep the data lines unchanged from strobe rise until the load has happened, which takes the synchronizer depth plus one clock cycles. After that the bus may change freely. Nothing changes at the output until the strobe has gone low and risen again.

The synchronizer depth is a parameter. A depth below two stops elaboration.

Top module: `par_bus_capture`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the word output is all zeros and the valid output is low.
- R2: Each low-to-high transition of the strobe produces exactly one valid pulse of one cycle, however long the strobe then stays high.
- R3: The valid pulse and the new word appear together, SYNC_STAGES+1 rising clock edges after the strobe rises (3 edges with the default depth of 2). Valid is low on every other edge.
- R4: The word presented with valid equals the value held on the data lines while the strobe was rising and during the capture interval.
- R5: Changes on the data lines outside a capture leave the word output unchanged. This covers changes while the strobe is high after the load, and changes while the strobe is low.
- R6: A high-to-low transition of the strobe produces no valid pulse and leaves the word output unchanged.
- R7: A strobe held high across a reset is seen as a new rising edge after reset release. It yields one capture SYNC_STAGES+1 edges after the first clock edge with reset low.
- R8: Successive strobe pulses, each with a low time of at least SYNC_STAGES+1 cycles, each deliver their own word in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_async | input | 1 | Sender strobe, asynchronous; rises once the data lines are stable |
| data_async | input | DATA_W | Sender data lines, asynchronous |
| data_o | output | DATA_W | Most recently captured word |
| valid_o | output | 1 | One-cycle pulse marking a newly captured word |

## Verification
The bench raises the strobe at a falling clock edge. From then on it counts rising edges and checks the outputs at every falling edge that follows. It expects valid and the new word exactly at edge SYNC_STAGES+1, and expects valid low and the word unchanged at every other count. It keeps counting past the capture while it disturbs the data lines, so late loads, extra pulses and loads from an unsettled bus all show up at a known edge. After a reset release it applies the same edge count starting from the first edge with reset low.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        if (rst) begin
            st_d.chain = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];

    // R7: after reset the synchronized level starts low
    a_r7_sync_cleared: assert property (@(posedge clk) $fell(rst) |-> !sync_out);
endmodule

// File: rtl/pbc_edge.sv
module pbc_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev = level_in;
        if (rst) begin
            st_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rise_o = level_in & ~st_q.prev;

    // R2: no two rising detections on consecutive cycles
    a_r2_rise_isolated: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pbc_capture.sv
module pbc_capture #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             valid
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             vld;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (load) begin
            st_d.word = din;
            st_d.vld  = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout  = st_q.word;
    assign valid = st_q.vld;

    // R2: valid lasts exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R5: the word only moves alongside a valid pulse
    a_r5_word_held: assert property (@(posedge clk) disable iff (rst)
        (!valid && !$past(rst)) |-> $stable(dout));
endmodule

// File: rtl/par_bus_capture.sv
module par_bus_capture #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_async,
    input  logic [DATA_W-1:0] data_async,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    import pbc_pkg::*;

    localparam int LATENCY = SYNC_STAGES + 1;

    generate
        if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
            $error("par_bus_capture: SYNC_STAGES must be at least %0d", MIN_SYNC_STAGES);
        end
    endgenerate

    logic strobe_sync;
    logic strobe_rise;

    pbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (strobe_async),
        .sync_out (strobe_sync)
    );

    pbc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .level_in (strobe_sync),
        .rise_o (strobe_rise)
    );

    pbc_capture #(.WIDTH(DATA_W)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .load  (strobe_rise),
        .din   (data_async),
        .dout  (data_o),
        .valid (valid_o)
    );

    // R3/R6: valid follows a low-then-high synchronized strobe, never a fall
    a_r6_rise_origin: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(rst)) |-> ($past(strobe_sync) && !$past(strobe_sync, 2)));
    // R4: presented word is what the bus held at the load edge
    a_r4_word_match: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(rst)) |-> (data_o == $past(data_async)));
endmodule

// File: tb/par_bus_capture_bench.sv
module par_bus_capture_bench;
    localparam int DW  = 16;
    localparam int NS  = 2;
    localparam int LAT = NS + 1;
    localparam int NV  = 6;

    // each vector: {word captured, garbage driven after capture}
    localparam logic [2*DW-1:0] VEC [NV] = '{
        {16'hA5C3, 16'h5A3C},
        {16'h0000, 16'hFFFF},
        {16'hFFFF, 16'h0000},
        {16'h1234, 16'hEDCB},
        {16'h8001, 16'h7FFE},
        {16'h00FF, 16'hFF00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [DW-1:0] bus = '0;
    logic [DW-1:0] data_o;
    logic          valid_o;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] held = '0;

    always #4 clk = ~clk;

    par_bus_capture #(.DATA_W(DW), .SYNC_STAGES(NS)) u_par_bus_capture (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (strobe),
        .data_async   (bus),
        .data_o       (data_o),
        .valid_o      (valid_o)
    );

    task automatic expect_out(input string req, input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (valid_o !== ev || data_o !== ed) begin
            errors++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, valid_o, data_o, ev, ed);
        end
    endtask

    // strobe rises at a falling edge; count rising edges and check each one
    task automatic strobe_word(input logic [DW-1:0] w, input logic [DW-1:0] junk,
                               input int high_cycles, input string req);
        bus = w;
        @(negedge clk);
        strobe = 1'b1;
        for (int k = 1; k <= high_cycles; k++) begin
            @(negedge clk);
            if (k == LAT) begin
                held = w;
                expect_out(req, 1'b1, held);       // R3 R4
                bus = junk;                         // R5: bus moves after capture
            end else begin
                expect_out(req, 1'b0, held);       // R2 R5
            end
        end
        strobe = 1'b0;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            expect_out("R6", 1'b0, held);
            bus = ~bus;                             // R5: bus moves while strobe low
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                expect_out("R1", 1'b0, '0);
                rst = 1'b0;
                @(negedge clk);
                expect_out("R1", 1'b0, '0);

                // table walk: R3 R4 R5 R6 R8
                for (int i = 0; i < NV; i++) begin
                    strobe_word(VEC[i][2*DW-1:DW], VEC[i][DW-1:0], LAT + 2, "R8");
                end

                // long strobe: one pulse only, R2
                strobe_word(16'hBEEF, 16'h4110, 25, "R2");

                // strobe held across reset, R7
                bus = 16'hC0DE;
                strobe = 1'b1;
                rst = 1'b1;
                repeat (3) @(negedge clk);
                expect_out("R1", 1'b0, '0);
                held = '0;
                rst = 1'b0;
                for (int k = 1; k <= LAT + 3; k++) begin
                    @(negedge clk);
                    if (k == LAT) begin
                        held = 16'hC0DE;
                        expect_out("R7", 1'b1, held);
                    end else begin
                        expect_out("R7", 1'b0, held);
                    end
                end
                strobe = 1'b0;
                repeat (LAT + 1) @(negedge clk);
                expect_out("R6", 1'b0, held);
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule